// File: doc/BRIEF.md
# HID Report Event Sequencer

This block decides when a four-byte status report has to go upstream toward the host, and it sends that report as a stream of bytes. A report is triggered by two kinds of event. One is a change in the registered button word, whether a button is pressed or released. The other is any byte that the microcontroller writes into one of its three report registers. The block captures all four bytes at the moment sending starts. It then presents them one at a time on a valid/ready byte interface, always in the same order: the button word first, then report registers 1, 2 and 3.

Events can arrive while a report is still in flight. These do not start a second stream at once. They set a single pending flag, so exactly one more report follows, and that report carries the latest values. In the other direction, a byte coming down from the host is written into a mailbox register and raises an interrupt level toward the microcontroller. The interrupt stays set until the microcontroller reads the mailbox. Because it is a level, the microcontroller can also poll it.

Top module: `hidrpt_seq_top`

## Requirements
- R1: After a synchronous active-low reset, `up_valid_o` is 0, `mbx_irq_o` is 0 and `mbx_data_o` is 0. With the buttons held steady, no report starts.
- R2: Any change of `btn_i` produces one report of exactly four bytes. Byte 0 is the button word, and bytes 1, 2 and 3 are report registers 1, 2 and 3 in that order. `up_last_o` is 1 only while byte 3 is offered.
- R3: A write with `mcu_wr_i`=1 and `mcu_addr_i` equal to 1, 2 or 3 stores `mcu_wdata_i` in that register and triggers a report that carries the new value.
- R4: A write to address 0 changes no register and triggers no report.
- R5: While `up_valid_o`=1 and `up_ready_i`=0, `up_valid_o` stays 1 and `up_data_o` stays unchanged. A byte is consumed only on a cycle where both are 1.
- R6: Any number of triggers that arrive during a report merge into exactly one further report. That report starts right after the current one and reflects all of those triggers.
- R7: The four bytes of a report are a snapshot taken when sending starts. Register writes made during the report do not change the bytes of that report.
- R8: When no trigger occurs, `up_valid_o` stays 0.
- R9: A cycle with `dn_valid_i`=1 stores `dn_data_i` in the mailbox and sets `mbx_irq_o` from the next cycle on.
- R10: `mbx_rd_i`=1 clears `mbx_irq_o` on the next cycle. If a host byte arrives in the same cycle, the new byte is stored and `mbx_irq_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_i | input | 8 | Button status word |
| mcu_wr_i | input | 1 | Microcontroller write strobe |
| mcu_addr_i | input | 2 | Register address of the write (1..3 writable) |
| mcu_wdata_i | input | 8 | Write data |
| up_valid_o | output | 1 | Upstream byte valid |
| up_ready_i | input | 1 | Upstream sink ready |
| up_data_o | output | 8 | Upstream report byte |
| up_last_o | output | 1 | Marks byte 3 of a report |
| dn_valid_i | input | 1 | Host downstream byte strobe |
| dn_data_i | input | 8 | Host downstream byte |
| mbx_rd_i | input | 1 | Microcontroller reads the mailbox |
| mbx_data_o | output | 8 | Mailbox contents |
| mbx_irq_o | output | 1 | Mailbox interrupt / poll flag |

## Verification
The bench writes three registers while the first byte of a report is stalled. It expects the stalled report to keep its old snapshot, then exactly one follow-up report with all three new values, then silence. A design without a snapshot would mix values inside one report. A design that queues each trigger separately would send extra reports, and one that drops pending triggers would send none. The bench also writes to address 0 and then checks that no stream starts and that later reports show the registers unchanged. It stalls ready to catch a byte that moves while it is not accepted. Finally, it issues a mailbox read in the same cycle as a host byte, to catch a read that wins over the new arrival and silently loses the interrupt.

// File: rtl/hidrpt_pkg.sv
// Package hidrpt_pkg: shared sizes and the sequencer state type.
// Assumes a report is one button byte plus one byte per writable register.
package hidrpt_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned ADDR_W   = 2;
    localparam int unsigned RPT_LEN  = 1 << ADDR_W;
    localparam int unsigned IDX_W    = ADDR_W;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_SEND = 1'b1
    } seq_state_e;
endpackage

// File: rtl/hidrpt_btn_watch.sv
// Module hidrpt_btn_watch: registers the button word and flags a change.
// Assumes btn_i is already synchronous to clk and debounced upstream.
// chg_o is high for one cycle after each sampled change of the word.
module hidrpt_btn_watch #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] btn_i,
    output logic [W-1:0] btn_q_o,
    output logic         chg_o
);
    logic [W-1:0] btn_q;
    logic [W-1:0] btn_prev;

    // Sample the buttons and keep the previous sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            btn_q    <= '0;
            btn_prev <= '0;
        end else begin
            btn_q    <= btn_i;
            btn_prev <= btn_q;
        end
    end

    assign btn_q_o = btn_q;
    assign chg_o   = (btn_q != btn_prev);
endmodule

// File: rtl/hidrpt_regfile.sv
// Module hidrpt_regfile: the writable report registers 1..N-1.
// Address 0 is the button word and is read-only, so writes to it are dropped.
// Every accepted write raises wr_trig_o in the same cycle.
module hidrpt_regfile #(
    parameter int unsigned W  = 8,
    parameter int unsigned AW = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic [AW-1:0]           addr_i,
    input  logic [W-1:0]            wdata_i,
    output logic [((1<<AW)-1)*W-1:0] regs_o,
    output logic                    wr_trig_o
);
    localparam int unsigned NREG = (1 << AW) - 1;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [W-1:0] val;
        // Store one register when its own address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val <= '0;
            else if (wr_i && (addr_i == AW'(g + 1)))
                val <= wdata_i;
        end
        assign regs_o[g*W +: W] = val;
    end

    assign wr_trig_o = wr_i && (addr_i != '0);
endmodule

// File: rtl/hidrpt_serializer.sv
// Module hidrpt_serializer: snapshots a report and streams it byte by byte.
// Assumes trig_i pulses on any event; it is registered once, so the snapshot
// sees register writes made in the trigger cycle. Triggers arriving mid-report
// merge into a single pending follow-up report.
module hidrpt_serializer
    import hidrpt_pkg::*;
#(
    parameter int unsigned W = 8,
    parameter int unsigned N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           trig_i,
    input  logic [N*W-1:0] rpt_i,
    output logic           up_valid_o,
    input  logic           up_ready_i,
    output logic [W-1:0]   up_data_o,
    output logic           up_last_o
);
    localparam int unsigned CW = $clog2(N);
    localparam logic [CW-1:0] LAST_IDX = CW'(N - 1);

    seq_state_e     state;
    logic [N*W-1:0] snap;
    logic [CW-1:0]  cnt;
    logic           trig_q;
    logic           pend;
    logic           fin;

    assign fin = (state == SEQ_SEND) && up_ready_i && (cnt == LAST_IDX);

    // Delay the trigger by one cycle so writes have landed before the snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_i;
    end

    // Sequencer: start, advance on handshake, reload or go idle after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            snap  <= '0;
            cnt   <= '0;
            pend  <= 1'b0;
        end else if (state == SEQ_IDLE) begin
            if (trig_q || pend) begin
                snap  <= rpt_i;
                cnt   <= '0;
                pend  <= 1'b0;
                state <= SEQ_SEND;
            end
        end else if (fin) begin
            if (trig_q || pend) begin
                snap <= rpt_i;
                cnt  <= '0;
                pend <= 1'b0;
            end else begin
                state <= SEQ_IDLE;
            end
        end else begin
            if (up_ready_i) cnt <= cnt + 1'b1;
            if (trig_q)     pend <= 1'b1;
        end
    end

    assign up_valid_o = (state == SEQ_SEND);
    assign up_data_o  = snap[cnt*W +: W];
    assign up_last_o  = (state == SEQ_SEND) && (cnt == LAST_IDX);

    AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid_o && !up_ready_i) |=> (up_valid_o && $stable(up_data_o))); // R5
    AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_valid_o && trig_q) |=> up_valid_o); // R2
    AST_PEND_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> up_valid_o); // R6
    AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (up_last_o && up_ready_i && !trig_q && !pend) |=> !up_valid_o); // R2
endmodule

// File: rtl/hidrpt_mailbox.sv
// Module hidrpt_mailbox: holds one host byte and flags it to the microcontroller.
// A host byte and a read in the same cycle keep the flag set (arrival wins).
module hidrpt_mailbox #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dn_valid_i,
    input  logic [W-1:0] dn_data_i,
    input  logic         rd_i,
    output logic [W-1:0] data_o,
    output logic         irq_o
);
    // Capture the host byte and manage the interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            irq_o  <= 1'b0;
        end else if (dn_valid_i) begin
            data_o <= dn_data_i;
            irq_o  <= 1'b1;
        end else if (rd_i) begin
            irq_o  <= 1'b0;
        end
    end

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid_i |=> irq_o); // R9
    AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !dn_valid_i) |=> !irq_o); // R10
    AST_DATA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_valid_i |=> $stable(data_o)); // R9
endmodule

// File: rtl/hidrpt_seq_top.sv
// Module hidrpt_seq_top: report event sequencer with a downstream mailbox.
// Assumes all inputs are synchronous to clk. Upstream bytes use valid/ready.
module hidrpt_seq_top
    import hidrpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] btn_i,
    input  logic              mcu_wr_i,
    input  logic [ADDR_W-1:0] mcu_addr_i,
    input  logic [BYTE_W-1:0] mcu_wdata_i,
    output logic              up_valid_o,
    input  logic              up_ready_i,
    output logic [BYTE_W-1:0] up_data_o,
    output logic              up_last_o,
    input  logic              dn_valid_i,
    input  logic [BYTE_W-1:0] dn_data_i,
    input  logic              mbx_rd_i,
    output logic [BYTE_W-1:0] mbx_data_o,
    output logic              mbx_irq_o
);
    logic [BYTE_W-1:0]               btn_q;
    logic                            btn_chg;
    logic [(RPT_LEN-1)*BYTE_W-1:0]   regs;
    logic                            wr_trig;
    logic [RPT_LEN*BYTE_W-1:0]       rpt_vec;

    hidrpt_btn_watch #(.W(BYTE_W)) u_btn (
        .clk(clk), .rst_n(rst_n), .btn_i(btn_i),
        .btn_q_o(btn_q), .chg_o(btn_chg)
    );

    hidrpt_regfile #(.W(BYTE_W), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(mcu_wr_i), .addr_i(mcu_addr_i),
        .wdata_i(mcu_wdata_i), .regs_o(regs), .wr_trig_o(wr_trig)
    );

    assign rpt_vec = {regs, btn_q};

    hidrpt_serializer #(.W(BYTE_W), .N(RPT_LEN)) u_ser (
        .clk(clk), .rst_n(rst_n), .trig_i(btn_chg | wr_trig), .rpt_i(rpt_vec),
        .up_valid_o(up_valid_o), .up_ready_i(up_ready_i),
        .up_data_o(up_data_o), .up_last_o(up_last_o)
    );

    hidrpt_mailbox #(.W(BYTE_W)) u_mbx (
        .clk(clk), .rst_n(rst_n), .dn_valid_i(dn_valid_i), .dn_data_i(dn_data_i),
        .rd_i(mbx_rd_i), .data_o(mbx_data_o), .irq_o(mbx_irq_o)
    );

    AST_ADDR0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mcu_wr_i && mcu_addr_i == '0) |=> $stable(regs)); // R4
endmodule

// File: tb/hidrpt_seq_top_tb.sv
module hidrpt_seq_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] btn_i = '0;
    logic       mcu_wr_i = 1'b0;
    logic [1:0] mcu_addr_i = '0;
    logic [7:0] mcu_wdata_i = '0;
    logic       up_valid_o;
    logic       up_ready_i = 1'b0;
    logic [7:0] up_data_o;
    logic       up_last_o;
    logic       dn_valid_i = 1'b0;
    logic [7:0] dn_data_i = '0;
    logic       mbx_rd_i = 1'b0;
    logic [7:0] mbx_data_o;
    logic       mbx_irq_o;

    int total = 0;
    int bad = 0;
    logic [7:0] rb [4];
    logic [7:0] m_reg [4];

    always #2 clk = ~clk;

    hidrpt_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .mcu_wr_i(mcu_wr_i),
        .mcu_addr_i(mcu_addr_i), .mcu_wdata_i(mcu_wdata_i),
        .up_valid_o(up_valid_o), .up_ready_i(up_ready_i), .up_data_o(up_data_o),
        .up_last_o(up_last_o), .dn_valid_i(dn_valid_i), .dn_data_i(dn_data_i),
        .mbx_rd_i(mbx_rd_i), .mbx_data_o(mbx_data_o), .mbx_irq_o(mbx_irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mcu_write(input logic [1:0] a, input logic [7:0] d);
        mcu_wr_i = 1'b1; mcu_addr_i = a; mcu_wdata_i = d;
        @(negedge clk);
        mcu_wr_i = 1'b0;
        if (a != 2'd0) m_reg[a] = d;
    endtask

    task automatic wait_valid(input string req);
        int n = 0;
        while (!up_valid_o && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(req, up_valid_o, 1'b1);
    endtask

    // Receive one report into rb; optional stall cycles per byte check holding.
    task automatic recv_report(input string req, input int stall);
        for (int i = 0; i < 4; i++) begin
            wait_valid(req);
            for (int s = 0; s < stall; s++) begin
                logic [7:0] d0 = up_data_o;
                @(negedge clk);
                chk("R5 hold", {up_valid_o, up_data_o}, {1'b1, d0});
            end
            rb[i] = up_data_o;
            chk("R2 last flag", up_last_o, (i == 3));
            up_ready_i = 1'b1;
            @(negedge clk);
            up_ready_i = 1'b0;
        end
    endtask

    task automatic expect_report(input string req, input logic [7:0] b0,
                                 input logic [7:0] b1, input logic [7:0] b2,
                                 input logic [7:0] b3);
        chk(req, {rb[0], rb[1], rb[2], rb[3]}, {b0, b1, b2, b3});
    endtask

    task automatic expect_quiet(input string req, input int cyc);
        logic seen = 1'b0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (up_valid_o) seen = 1'b1;
        end
        chk(req, seen, 1'b0);
    endtask

    task automatic t_reset;
        chk("R1 valid", up_valid_o, 1'b0);
        chk("R1 irq", mbx_irq_o, 1'b0);
        chk("R1 mbx", mbx_data_o, 8'h00);
        expect_quiet("R8 idle", 10);
    endtask

    task automatic t_button;
        btn_i = 8'h05;
        recv_report("R2 press", 0);
        expect_report("R2 press order", 8'h05, 8'h00, 8'h00, 8'h00);
        expect_quiet("R8 after press", 6);
        btn_i = 8'h00;
        recv_report("R2 release", 0);
        expect_report("R2 release order", 8'h00, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_write;
        mcu_write(2'd1, 8'hA1);
        recv_report("R3 w1", 1);
        expect_report("R3 w1 bytes", 8'h00, 8'hA1, 8'h00, 8'h00);
        mcu_write(2'd3, 8'hC3);
        recv_report("R3 w3", 0);
        expect_report("R3 w3 bytes", 8'h00, 8'hA1, 8'h00, 8'hC3);
        mcu_write(2'd2, 8'hB2);
        recv_report("R3 w2", 3);
        expect_report("R3 w2 bytes", 8'h00, 8'hA1, 8'hB2, 8'hC3);
    endtask

    task automatic t_addr0;
        mcu_write(2'd0, 8'h77);
        expect_quiet("R4 no report", 8);
        btn_i = 8'h80;
        recv_report("R4 probe", 0);
        expect_report("R4 regs unchanged", 8'h80, 8'hA1, 8'hB2, 8'hC3);
    endtask

    task automatic t_merge;
        mcu_write(2'd1, 8'h11);
        wait_valid("R6 start");
        mcu_write(2'd2, 8'h22);
        mcu_write(2'd3, 8'h33);
        mcu_write(2'd1, 8'h44);
        recv_report("R7 snapshot", 0);
        expect_report("R7 snapshot bytes", 8'h80, 8'h11, 8'hB2, 8'hC3);
        recv_report("R6 merged", 0);
        expect_report("R6 merged bytes", 8'h80, 8'h44, 8'h22, 8'h33);
        expect_quiet("R6 single follow-up", 10);
    endtask

    task automatic t_mailbox;
        dn_valid_i = 1'b1; dn_data_i = 8'h5A;
        @(negedge clk);
        dn_valid_i = 1'b0;
        chk("R9 data", mbx_data_o, 8'h5A);
        chk("R9 irq", mbx_irq_o, 1'b1);
        @(negedge clk);
        chk("R9 irq held", mbx_irq_o, 1'b1);
        mbx_rd_i = 1'b1;
        @(negedge clk);
        mbx_rd_i = 1'b0;
        chk("R10 cleared", mbx_irq_o, 1'b0);
        chk("R10 data kept", mbx_data_o, 8'h5A);
        mbx_rd_i = 1'b1; dn_valid_i = 1'b1; dn_data_i = 8'hE7;
        @(negedge clk);
        mbx_rd_i = 1'b0; dn_valid_i = 1'b0;
        chk("R10 arrival wins irq", mbx_irq_o, 1'b1);
        chk("R10 arrival wins data", mbx_data_o, 8'hE7);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_reg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_button();
        t_write();
        t_addr0();
        t_merge();
        t_mailbox();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule